// File: doc/BRIEF.md
# Shared Memory Port Arbiter for a Write Path and a Read Path

This block lets two independent requestors use one memory controller port. One requestor only writes and the other only reads, and both must see the same storage. The block decides which side owns the controller port. It then switches that side's address, write data, byte enables and command onto the single port. Stall and read-return indications go back only to the side that holds the grant. The side without the grant sees a permanent stall.

Each change of owner usually makes the memory open a different row, and that costs cycles. For this reason the grant is sticky. The owner keeps the port while it still has work, for up to `MAX_HOLD` accepted transfers. After that limit, if the other side is waiting, the owner must hand over, so no requestor waits without bound. If the owner goes quiet while the other side is asking, the grant moves at the next clock edge. A hand-over happens only when nothing is in flight: no command held in a stall, and no read data still to come. This keeps returned data from being routed to the wrong side. When both sides ask at the same time from the idle state, the read side wins.

Requestors use a request/wait handshake. A transfer is accepted in a cycle where the request is high and the wait is low. The requestor must hold its command unchanged while the wait is high.

Top module: `mem_share_arb`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with no requests, `wr_wait` and `rd_wait` are both 1 and neither `m_read` nor `m_write` is asserted.
- R2: The granted side's command drives the memory port. For the write side, `m_addr`, `m_wdata` and `m_be` equal `wr_addr`, `wr_data` and `wr_be`. For the read side, `m_addr` equals `rd_addr`. A requestor sees acceptance (request high, wait low) exactly when the memory port accepts the command. Byte enable bit i controls data bits 8i+7 down to 8i.
- R3: The side without the grant has its wait held at 1. The two requestors are never both released in the same cycle.
- R4: From idle, a request is granted at the next clock edge, so the first command reaches the memory port in the cycle after the request rises. If both sides request in the same cycle, the read side is served first.
- R5: When both sides request continuously, the owner completes exactly `MAX_HOLD` accepted transfers before the other side gets the port. Grants therefore alternate in runs of `MAX_HOLD`, starting with reads.
- R6: When the write owner drops its request while the read side is waiting, the first read is accepted two cycles after the last accepted write.
- R7: The owner never changes while a command is stalled or read data is outstanding. A stalled command stays unchanged on the memory port until it is accepted.
- R8: `rd_valid` follows `m_rvalid` for reads issued by the read side. `rd_data` carries `m_rdata`. Each accepted read yields exactly one `rd_valid` pulse.
- R9: `m_read` and `m_write` are never both asserted. With no requests pending, the port goes idle with both waits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write side command request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_be | input | DW/8 | Write byte enables |
| wr_wait | output | 1 | Stall toward the write side |
| rd_req | input | 1 | Read side command request |
| rd_addr | input | AW | Read address |
| rd_wait | output | 1 | Stall toward the read side |
| rd_valid | output | 1 | Read data valid toward the read side |
| rd_data | output | DW | Read data toward the read side |
| m_addr | output | AW | Memory port address |
| m_wdata | output | DW | Memory port write data |
| m_be | output | DW/8 | Memory port byte enables |
| m_write | output | 1 | Memory port write command |
| m_read | output | 1 | Memory port read command |
| m_wait | input | 1 | Memory port stall |
| m_rvalid | input | 1 | Memory port read data valid |
| m_rdata | input | DW | Memory port read data |

## Verification
Some properties can be checked on every cycle. These are the exclusive command, the blocked waits of the side without the grant, an owner that stays frozen across a stalled command or a just-accepted read, read-valid appearing only with a memory response, and read priority from idle. Other behaviour only shows up in the bench's scenarios. This covers the run lengths of exactly `MAX_HOLD` under continuous contention, both with and without random memory stalls, and the two-cycle hand-over when the owner goes idle. It also covers the merge of byte-enabled writes into memory, and one correct data return for every read.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_WR   = 2'd1,
      OWN_RD   = 2'd2
   } owner_e;
endpackage

// File: rtl/arb_pend_ctr.sv
// Tracks reads accepted by the memory port whose data has not yet returned.
module arb_pend_ctr #(
   parameter int MAX_PEND = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_acc,
   input  logic rsp_vld,
   output logic pend_full,
   output logic pend_zero_nx
);
   localparam int CW = $clog2(MAX_PEND + 1);

   generate
      if (MAX_PEND == 1) begin : g_flag
         logic busy_q, busy_nx;
         assign busy_nx      = rd_acc | (busy_q & ~rsp_vld);
         assign pend_full    = busy_q;
         assign pend_zero_nx = ~busy_nx;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= busy_nx;
         end
      end else begin : g_cnt
         localparam logic [CW-1:0] LIM = CW'(MAX_PEND);
         logic [CW-1:0] cnt_q, cnt_nx;
         always_comb begin
            cnt_nx = cnt_q + CW'(rd_acc) - CW'(rsp_vld);
         end
         assign pend_full    = (cnt_q == LIM);
         assign pend_zero_nx = (cnt_nx == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_nx;
         end
      end
   endgenerate
endmodule

// File: rtl/arb_grant_ctl.sv
// Owner selection with sticky hold, bounded by MAX_HOLD accepted transfers.
module arb_grant_ctl
   import mem_arb_pkg::*;
#(
   parameter int MAX_HOLD = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_req,
   input  logic   rd_req,
   input  logic   cmd_stalled,
   input  logic   xfer_acc,
   input  logic   pend_zero_nx,
   output owner_e owner,
   output logic   yield_q
);
   localparam int HW = $clog2(MAX_HOLD + 1);

   owner_e owner_nx, other;
   logic   own_req, oth_req, reach_nx, hold_clr, can_move, yield_nx;

   assign hold_clr = (owner_nx != owner);

   generate
      if (MAX_HOLD == 1) begin : g_flag
         logic done_q;
         assign reach_nx = done_q | xfer_acc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        done_q <= 1'b0;
            else if (hold_clr) done_q <= 1'b0;
            else if (xfer_acc) done_q <= 1'b1;
         end
      end else begin : g_cnt
         localparam logic [HW-1:0] LIM = HW'(MAX_HOLD);
         logic [HW-1:0] cnt_q, cnt_nx;
         always_comb begin
            cnt_nx = (xfer_acc && cnt_q != LIM) ? cnt_q + 1'b1 : cnt_q;
         end
         assign reach_nx = (cnt_nx == LIM);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (hold_clr) cnt_q <= '0;
            else               cnt_q <= cnt_nx;
         end
      end
   endgenerate

   always_comb begin
      unique case (owner)
         OWN_WR: begin own_req = wr_req; oth_req = rd_req; other = OWN_RD; end
         OWN_RD: begin own_req = rd_req; oth_req = wr_req; other = OWN_WR; end
         default: begin own_req = 1'b0; oth_req = 1'b0; other = OWN_NONE; end
      endcase
   end

   assign can_move = ~cmd_stalled & pend_zero_nx;

   always_comb begin
      owner_nx = owner;
      if (owner == OWN_NONE) begin
         if (rd_req)      owner_nx = OWN_RD;
         else if (wr_req) owner_nx = OWN_WR;
      end else if (can_move) begin
         if (!own_req || yield_q)      owner_nx = oth_req ? other : OWN_NONE;
         else if (reach_nx && oth_req) owner_nx = other;
      end
   end

   always_comb begin
      if (owner_nx != owner)
         yield_nx = 1'b0;
      else if (owner != OWN_NONE && reach_nx && oth_req && !cmd_stalled)
         yield_nx = 1'b1;
      else
         yield_nx = yield_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner   <= OWN_NONE;
         yield_q <= 1'b0;
      end else begin
         owner   <= owner_nx;
         yield_q <= yield_nx;
      end
   end
endmodule

// File: rtl/arb_port_mux.sv
// Steers the granted side onto the memory port and routes responses back.
module arb_port_mux
   import mem_arb_pkg::*;
#(
   parameter int AW = 24,
   parameter int DW = 32
) (
   input  owner_e          owner,
   input  logic            yield_q,
   input  logic            pend_full,
   input  logic            wr_req,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [DW/8-1:0] wr_be,
   output logic            wr_wait,
   input  logic            rd_req,
   input  logic [AW-1:0]   rd_addr,
   output logic            rd_wait,
   output logic            rd_valid,
   output logic [DW-1:0]   rd_data,
   output logic [AW-1:0]   m_addr,
   output logic [DW-1:0]   m_wdata,
   output logic [DW/8-1:0] m_be,
   output logic            m_write,
   output logic            m_read,
   input  logic            m_wait,
   input  logic            m_rvalid,
   input  logic [DW-1:0]   m_rdata
);
   logic own_wr, own_rd, wr_go, rd_go;

   assign own_wr = (owner == OWN_WR);
   assign own_rd = (owner == OWN_RD);
   assign wr_go  = own_wr & ~yield_q;
   assign rd_go  = own_rd & ~yield_q & ~pend_full;

   assign m_write = wr_go & wr_req;
   assign m_read  = rd_go & rd_req;
   assign m_addr  = own_rd ? rd_addr : wr_addr;
   assign m_wdata = wr_data;
   assign m_be    = own_wr ? wr_be : '1;

   assign wr_wait = ~wr_go | m_wait;
   assign rd_wait = ~rd_go | m_wait;

   assign rd_valid = m_rvalid & own_rd;
   assign rd_data  = m_rdata;
endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb
   import mem_arb_pkg::*;
#(
   parameter int AW       = 24,
   parameter int DW       = 32,
   parameter int MAX_HOLD = 8,
   parameter int MAX_PEND = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_req,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [DW/8-1:0] wr_be,
   output logic            wr_wait,
   input  logic            rd_req,
   input  logic [AW-1:0]   rd_addr,
   output logic            rd_wait,
   output logic            rd_valid,
   output logic [DW-1:0]   rd_data,
   output logic [AW-1:0]   m_addr,
   output logic [DW-1:0]   m_wdata,
   output logic [DW/8-1:0] m_be,
   output logic            m_write,
   output logic            m_read,
   input  logic            m_wait,
   input  logic            m_rvalid,
   input  logic [DW-1:0]   m_rdata
);
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("mem_share_arb: DW must be a positive multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("mem_share_arb: AW must be at least 1");
   end
   if (MAX_HOLD < 1) begin : g_bad_hold
      $error("mem_share_arb: MAX_HOLD must be at least 1");
   end
   if (MAX_PEND < 1) begin : g_bad_pend
      $error("mem_share_arb: MAX_PEND must be at least 1");
   end

   owner_e owner;
   logic   yield_q, pend_full, pend_zero_nx;
   logic   cmd_stalled, xfer_acc, rd_acc;

   assign cmd_stalled = (m_read | m_write) & m_wait;
   assign xfer_acc    = (m_read | m_write) & ~m_wait;
   assign rd_acc      = m_read & ~m_wait;

   arb_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_acc       (rd_acc),
      .rsp_vld      (m_rvalid),
      .pend_full    (pend_full),
      .pend_zero_nx (pend_zero_nx)
   );

   arb_grant_ctl #(.MAX_HOLD(MAX_HOLD)) u_grant (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_req       (wr_req),
      .rd_req       (rd_req),
      .cmd_stalled  (cmd_stalled),
      .xfer_acc     (xfer_acc),
      .pend_zero_nx (pend_zero_nx),
      .owner        (owner),
      .yield_q      (yield_q)
   );

   arb_port_mux #(.AW(AW), .DW(DW)) u_mux (
      .owner     (owner),
      .yield_q   (yield_q),
      .pend_full (pend_full),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_be     (wr_be),
      .wr_wait   (wr_wait),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_wait   (rd_wait),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .m_addr    (m_addr),
      .m_wdata   (m_wdata),
      .m_be      (m_be),
      .m_write   (m_write),
      .m_read    (m_read),
      .m_wait    (m_wait),
      .m_rvalid  (m_rvalid),
      .m_rdata   (m_rdata)
   );
endmodule

// File: rtl/mem_share_arb_chk.sv
module mem_share_arb_chk
   import mem_arb_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input owner_e owner,
   input logic   rd_req,
   input logic   rd_wait,
   input logic   wr_wait,
   input logic   rd_valid,
   input logic   m_read,
   input logic   m_write,
   input logic   m_wait,
   input logic   m_rvalid
);
   // R9
   a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_read && m_write));

   // R3
   a_r3_rd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != OWN_RD) |-> rd_wait);

   // R3
   a_r3_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != OWN_WR) |-> wr_wait);

   // R7
   a_r7_stall_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_read || m_write) && m_wait) |=> $stable(owner));

   // R7
   a_r7_read_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && !m_wait) |=> $stable(owner));

   // R8
   a_r8_valid_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> m_rvalid);

   // R4
   a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_NONE && rd_req) |=> (owner == OWN_RD));
endmodule

bind mem_share_arb mem_share_arb_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .owner    (owner),
   .rd_req   (rd_req),
   .rd_wait  (rd_wait),
   .wr_wait  (wr_wait),
   .rd_valid (rd_valid),
   .m_read   (m_read),
   .m_write  (m_write),
   .m_wait   (m_wait),
   .m_rvalid (m_rvalid)
);

// File: tb/sim_mem_share_arb.sv
`timescale 1ns/1ps
module sim_mem_share_arb;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int HOLD = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_req = 1'b0, rd_req = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0, m_addr;
   logic [DW-1:0] wr_data = '0, rd_data, m_wdata, m_rdata = '0;
   logic [1:0] wr_be = 2'b11, m_be;
   logic wr_wait, rd_wait, rd_valid, m_write, m_read;
   logic m_wait = 1'b0, m_rvalid = 1'b0;

   always #4 clk = ~clk;

   mem_share_arb #(.AW(AW), .DW(DW), .MAX_HOLD(HOLD), .MAX_PEND(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_wait(wr_wait),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_wait(rd_wait), .rd_valid(rd_valid), .rd_data(rd_data),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be), .m_write(m_write), .m_read(m_read),
      .m_wait(m_wait), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
   );

   int total = 0, bad = 0, cyc = 0;
   bit fin = 1'b0;
   logic [15:0] mem [256];

   // requestor and memory model state
   bit rd_en, wr_en, stall_en;
   int rd_n, wr_n, rd_base, wr_base, rd_idx, wr_idx;
   bit be_lo_first;
   bit acc_r, acc_w;
   logic [AW-1:0] w_a, r_a, prev_addr;
   logic [DW-1:0] w_d;
   logic [1:0] w_be;
   bit s1v;
   logic [AW-1:0] s1a, ret_a;
   logic [7:0] lfsr;
   bit prev_stall_r, prev_stall_w;
   int rv_cnt, first_acc, last_w_cyc, first_r_cyc, last_t, run_len, n_runs;
   int run_len_a [64];
   int run_typ_a [64];

   function automatic logic [15:0] init_val(int a);
      return 16'(a * 7 + 3);
   endfunction
   function automatic logic [15:0] wdat(int a);
      return 16'(a * 13 + 'h5A00);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic clear_book();
      rd_en = 0; wr_en = 0; stall_en = 0; rd_n = 0; wr_n = 0;
      rd_idx = 0; wr_idx = 0; be_lo_first = 0;
      acc_r = 0; acc_w = 0; s1v = 0; prev_stall_r = 0; prev_stall_w = 0;
      rv_cnt = 0; first_acc = -1; last_w_cyc = -1; first_r_cyc = -1;
      last_t = 0; run_len = 0; n_runs = 0; lfsr = 8'h5B;
   endtask

   task automatic close_run();
      if (last_t != 0 && n_runs < 64) begin
         run_len_a[n_runs] = run_len;
         run_typ_a[n_runs] = last_t;
         n_runs++;
      end
      last_t = 0; run_len = 0;
   endtask

   task automatic step();
      @(negedge clk);
      // memory model: apply last cycle's accepted commands
      if (acc_w)
         for (int b = 0; b < 2; b++)
            if (w_be[b]) mem[w_a][8*b +: 8] = w_d[8*b +: 8];
      m_rvalid = s1v;
      ret_a    = s1a;
      m_rdata  = s1v ? mem[s1a] : '0;
      s1v = acc_r;
      s1a = r_a;
      if (acc_r) rd_idx++;
      if (acc_w) wr_idx++;
      // requestors
      rd_req  = rd_en && (rd_idx < rd_n);
      rd_addr = AW'(rd_base + rd_idx);
      wr_req  = wr_en && (wr_idx < wr_n);
      wr_addr = AW'(wr_base + wr_idx);
      wr_data = wdat(wr_base + wr_idx);
      wr_be   = (be_lo_first && wr_idx == 0) ? 2'b01 : 2'b11;
      m_wait  = stall_en ? (lfsr[0] & lfsr[2]) : 1'b0;
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      #1;
      acc_r = rd_req && !rd_wait;
      acc_w = wr_req && !wr_wait;
      r_a = rd_addr; w_a = wr_addr; w_d = wr_data; w_be = wr_be;
      if (rst_n) begin
         // R9: exclusive command
         if (m_read && m_write) chk(0, "R9", "both commands", 1, 0);
         // R3: never both released; non-owner blocked
         if (!rd_wait && !wr_wait) chk(0, "R3", "both released", 1, 0);
         if (m_read && !wr_wait) chk(0, "R3", "wr_wait during read", wr_wait, 1);
         if (m_write && !rd_wait) chk(0, "R3", "rd_wait during write", rd_wait, 1);
         // R2: acceptance seen by requestor matches memory port
         if ((m_read && !m_wait) != acc_r) chk(0, "R2", "read accept", acc_r, m_read && !m_wait);
         if ((m_write && !m_wait) != acc_w) chk(0, "R2", "write accept", acc_w, m_write && !m_wait);
         if (m_read) chk(m_addr == rd_addr, "R2", "read addr", m_addr, rd_addr);
         if (m_write) begin
            chk(m_addr == wr_addr, "R2", "write addr", m_addr, wr_addr);
            chk(m_wdata == wr_data, "R2", "write data", m_wdata, wr_data);
            chk(m_be == wr_be, "R2", "byte enables", m_be, wr_be);
         end
         // R7: stalled command held unchanged
         if (prev_stall_r) chk(m_read && m_addr == prev_addr, "R7", "stalled read held", m_read, 1);
         if (prev_stall_w) chk(m_write && m_addr == prev_addr, "R7", "stalled write held", m_write, 1);
         prev_stall_r = m_read && m_wait;
         prev_stall_w = m_write && m_wait;
         prev_addr = m_addr;
         // R8: response routing and data
         chk(rd_valid == m_rvalid, "R8", "rd_valid", rd_valid, m_rvalid);
         if (rd_valid) begin
            rv_cnt++;
            chk(rd_data == init_val(int'(ret_a)), "R8", "rd_data", rd_data, init_val(int'(ret_a)));
         end
         // run bookkeeping
         if (acc_r || acc_w) begin
            if (first_acc < 0) first_acc = cyc;
            if (acc_w) last_w_cyc = cyc;
            if (acc_r && first_r_cyc < 0) first_r_cyc = cyc;
            if ((acc_r ? 2 : 1) == last_t) run_len++;
            else begin
               close_run();
               last_t = acc_r ? 2 : 1;
               run_len = 1;
            end
         end
      end
      cyc++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clear_book();
      repeat (3) begin
         step();
         chk(rd_wait && wr_wait, "R1", "waits in reset", {rd_wait, wr_wait}, 2'b11);
         chk(!m_read && !m_write, "R1", "cmd in reset", {m_read, m_write}, 0);
      end
      rst_n = 1'b1;
      step();
      chk(rd_wait && wr_wait, "R1", "waits after reset", {rd_wait, wr_wait}, 2'b11);
      chk(!m_read && !m_write, "R1", "cmd after reset", {m_read, m_write}, 0);
   endtask

   task automatic run_until_done();
      int guard = 0;
      while (!(rd_idx >= rd_n && wr_idx >= wr_n) && guard < 3000) begin
         step();
         guard++;
      end
      rd_en = 0; wr_en = 0;
      repeat (6) step();
      close_run();
   endtask

   task automatic check_idle();
      step();
      chk(rd_wait && wr_wait, "R9", "idle waits", {rd_wait, wr_wait}, 2'b11);
      chk(!m_read && !m_write, "R9", "idle port", {m_read, m_write}, 0);
   endtask

   task automatic check_runs(input int exp_runs, input string tag);
      chk(n_runs == exp_runs, "R5", {tag, " run count"}, n_runs, exp_runs);
      for (int i = 0; i < n_runs; i++) begin
         chk(run_len_a[i] == HOLD, "R5", {tag, " run length"}, run_len_a[i], HOLD);
         chk(run_typ_a[i] == ((i % 2 == 0) ? 2 : 1), "R4", {tag, " run order"},
             run_typ_a[i], (i % 2 == 0) ? 2 : 1);
      end
   endtask

   initial begin
      int start;
      for (int a = 0; a < 256; a++) mem[a] = init_val(a);

      // Scenario 1: contention from idle, no stalls (R4, R5, R2, R8)
      do_reset();
      rd_n = 12; wr_n = 12; rd_base = 0; wr_base = 128;
      rd_en = 1; wr_en = 1;
      start = cyc;
      run_until_done();
      chk(first_acc == start + 1, "R4", "grant latency", first_acc - start, 1);
      check_runs(8, "s1");
      chk(rv_cnt == 12, "R8", "s1 valid count", rv_cnt, 12);
      for (int i = 0; i < 12; i++)
         chk(mem[128 + i] == wdat(128 + i), "R2", "s1 stored", mem[128 + i], wdat(128 + i));
      check_idle();

      // Scenario 2: contention with random memory stalls (R7, R5)
      do_reset();
      rd_n = 9; wr_n = 9; rd_base = 32; wr_base = 160;
      stall_en = 1; rd_en = 1; wr_en = 1;
      run_until_done();
      check_runs(6, "s2");
      chk(rv_cnt == 9, "R8", "s2 valid count", rv_cnt, 9);
      for (int i = 0; i < 9; i++)
         chk(mem[160 + i] == wdat(160 + i), "R7", "s2 stored", mem[160 + i], wdat(160 + i));
      check_idle();

      // Scenario 3: write owner goes idle while reader waits (R6), byte enables (R2)
      do_reset();
      wr_n = 2; wr_base = 200; be_lo_first = 1; wr_en = 1;
      rd_n = 3; rd_base = 64;
      start = cyc;
      step();
      step();
      rd_en = 1;
      run_until_done();
      chk(first_acc == start + 1, "R4", "s3 grant latency", first_acc - start, 1);
      chk(last_w_cyc == start + 2, "R6", "last write cycle", last_w_cyc - start, 2);
      chk(first_r_cyc - last_w_cyc == 2, "R6", "hand-over gap", first_r_cyc - last_w_cyc, 2);
      chk(n_runs == 2 && run_len_a[0] == 2 && run_len_a[1] == 3, "R6", "s3 runs", n_runs, 2);
      chk(mem[200] == {init_val(200)[15:8], wdat(200)[7:0]}, "R2", "byte-enable merge",
          mem[200], {init_val(200)[15:8], wdat(200)[7:0]});
      chk(mem[201] == wdat(201), "R2", "full write", mem[201], wdat(201));
      chk(rv_cnt == 3, "R8", "s3 valid count", rv_cnt, 3);
      check_idle();

      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule